// File: doc/BRIEF.md
# ECC Error Capture Status Register

This block sits beside the ECC decoder of a 128-bit non-volatile memory read path. The read beat is split into a high and a low 64-bit word. For each word the decoder raises a single-error strobe or a dual-error strobe, and it supplies the byte address of the access. The block keeps one error-type code per word and one 24-bit byte address. It presents them as a 32-bit status word that software reads.

Capture is sticky and ordered by severity. While nothing is held, any error is recorded. Once a single error is held, only a dual error can replace the record. Once a dual error is held, the record is frozen. A read strobe clears both type codes and re-arms capture. If an error arrives in the same cycle as the read, that error is recorded in place of the clear. The address field is kept across a read until a later capture replaces it.

Top module: `ecc_err_capture`

## Requirements
- R1: The status word carries the high-word type in bits 31:30, the low-word type in bits 29:28 and the byte address in bits 23:0. Bits 27:24 are always zero. After reset the whole word is zero.
- R2: Type codes are 0 = none since the last read, 1 = at least one single error, 2 = at least one dual error. Code 3 never appears.
- R3: When no error is held, any error strobe is captured on the next clock edge. The type field of each reporting word becomes 1 or 2, and the address is updated.
- R4: While a single error is held, a later cycle carrying only single errors changes neither the type fields nor the address.
- R5: While a single error is held, a dual error is captured. It updates the address, and it raises the reporting word's type to 2. Any type already at 1 stays at 1 or rises, and never falls.
- R6: While a dual error is held, no error changes any field until a read.
- R7: A read strobe with no error in that cycle sets both type fields to 0 on the next edge. It keeps the address, and it re-arms capture for any error.
- R8: A read strobe together with an error in the same cycle leaves only that error recorded: its types and its address, with no earlier types kept.
- R9: When the same word reports a single and a dual error in one cycle, the dual error wins. That word's type becomes 2 and tracking is frozen.
- R10: When both words report an error in one cycle, both type fields update, and the address recorded is the access address with its low 4 bits cleared.
- R11: When only the high word reports, the address recorded is the access address with bits 3:0 replaced by 4'b1000. When only the low word reports, bits 3:0 are replaced by 4'b0000.
- R12: In the cycle the read strobe is high, the status word still shows the contents from before the clear. The clear is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hi_sgl_err_i | input | 1 | Single-error strobe for the high 64-bit word |
| hi_dbl_err_i | input | 1 | Dual-error strobe for the high 64-bit word |
| lo_sgl_err_i | input | 1 | Single-error strobe for the low 64-bit word |
| lo_dbl_err_i | input | 1 | Dual-error strobe for the low 64-bit word |
| rd_addr_i | input | 24 | Byte address of the current 128-bit access |
| stat_rd_i | input | 1 | One-cycle pulse: the status word is being read |
| status_o | output | 32 | Status word: types and captured address |

## Verification
Several properties are checked on every cycle:
- the reserved bits read zero and no type field holds code 3;
- a type field never falls except through a read;
- the address moves only when an error is captured;
- a held dual error freezes the whole word;
- a read with no error clears both type fields.

The bench's scenarios show the rest:
- the exact address chosen for high-only, low-only and two-word errors;
- a second single error being ignored;
- the mixed single-and-dual cases within one cycle;
- a read that coincides with a new error;
- the status word showing its old value during the read cycle.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SINGLE = 2'd1,
    ERR_DUAL   = 2'd2
  } err_kind_e;

  function automatic err_kind_e kind_max(input err_kind_e a, input err_kind_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ecc_err_sev_enc.sv
module ecc_err_sev_enc
  import ecc_err_pkg::*;
(
  input  logic      sgl_i,
  input  logic      dbl_i,
  output err_kind_e sev_o
);

  // Dual outranks single when both strobe together (R9)
  always_comb begin
    if (dbl_i)      sev_o = ERR_DUAL;
    else if (sgl_i) sev_o = ERR_SINGLE;
    else            sev_o = ERR_NONE;
  end

endmodule

// File: rtl/ecc_err_capture_ctl.sv
module ecc_err_capture_ctl
  import ecc_err_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_clr_i,
  input  err_kind_e held_hi_i,
  input  err_kind_e held_lo_i,
  input  err_kind_e sev_hi_i,
  input  err_kind_e sev_lo_i,
  output err_kind_e base_hi_o,
  output err_kind_e base_lo_o,
  output logic      capture_o
);

  err_kind_e level_eff;
  err_kind_e event_sev;

  always_comb begin
    base_hi_o = rd_clr_i ? ERR_NONE : held_hi_i;
    base_lo_o = rd_clr_i ? ERR_NONE : held_lo_i;
    level_eff = kind_max(base_hi_o, base_lo_o);
    event_sev = kind_max(sev_hi_i, sev_lo_i);
    capture_o = (event_sev > level_eff);
  end

  // R6: a held dual error without a read never permits a capture
  assert_dual_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr_i && (held_hi_i == ERR_DUAL || held_lo_i == ERR_DUAL)) |-> !capture_o);

  // R4: a lone single event over a held single is not captured
  assert_single_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr_i && (held_hi_i == ERR_SINGLE || held_lo_i == ERR_SINGLE)
     && sev_hi_i != ERR_DUAL && sev_lo_i != ERR_DUAL) |-> !capture_o);

endmodule

// File: rtl/ecc_err_type_reg.sv
module ecc_err_type_reg
  import ecc_err_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_clr_i,
  input  logic      capture_i,
  input  err_kind_e base_i,
  input  err_kind_e sev_i,
  output err_kind_e type_q
);

  err_kind_e type_d;
  logic      type_en;

  always_comb begin
    type_en = capture_i | rd_clr_i;
    type_d  = capture_i ? kind_max(base_i, sev_i) : base_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       type_q <= ERR_NONE;
    else if (type_en) type_q <= type_d;
  end

  // R2: reserved code never held
  assert_no_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    type_q != 2'd3);

  // R5: without a read a type never falls
  assert_no_downgrade_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> (type_q >= $past(type_q)));

  // R7: read with nothing captured clears the field
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !capture_i) |=> (type_q == ERR_NONE));

endmodule

// File: rtl/ecc_err_addr_reg.sv
module ecc_err_addr_reg #(
  parameter int ADDR_W   = 24,
  parameter int BEAT_LSB = 4,
  parameter int HALF_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              err_hi_i,
  input  logic              err_lo_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [ADDR_W-1:0] addr_q
);

  localparam logic [ADDR_W-1:0] HALF_OFS = ADDR_W'(1) << HALF_LSB;

  logic [ADDR_W-1:0] beat_base;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    beat_base = {rd_addr_i[ADDR_W-1:BEAT_LSB], {BEAT_LSB{1'b0}}};
    if (err_hi_i && !err_lo_i) addr_d = beat_base | HALF_OFS;
    else                       addr_d = beat_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (capture_i) addr_q <= addr_d;
  end

  // R7: address holds unless a capture happens
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(addr_q));

  // R10: two-word capture stores a beat-aligned address
  assert_two_word_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && err_hi_i && err_lo_i) |=> (addr_q[BEAT_LSB-1:0] == '0));

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int BEAT_LSB = 4,
  parameter int HALF_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_sgl_err_i,
  input  logic              hi_dbl_err_i,
  input  logic              lo_sgl_err_i,
  input  logic              lo_dbl_err_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              stat_rd_i,
  output logic [31:0]       status_o
);

  localparam int STAT_W      = 32;
  localparam int TYPE_W      = 2;
  localparam int TYPE_HI_LSB = STAT_W - TYPE_W;
  localparam int TYPE_LO_LSB = TYPE_HI_LSB - TYPE_W;
  localparam int RSV_W       = TYPE_LO_LSB - ADDR_W;
  localparam int N_HALF      = 2;  // index 1 = high word, 0 = low word

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic      sgl_v [N_HALF];
  logic      dbl_v [N_HALF];
  err_kind_e sev_v  [N_HALF];
  err_kind_e base_v [N_HALF];
  err_kind_e held_v [N_HALF];
  logic      capture;

  always_comb begin
    sgl_v[1] = hi_sgl_err_i;
    dbl_v[1] = hi_dbl_err_i;
    sgl_v[0] = lo_sgl_err_i;
    dbl_v[0] = lo_dbl_err_i;
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    ecc_err_sev_enc u_sev (
      .sgl_i (sgl_v[h]),
      .dbl_i (dbl_v[h]),
      .sev_o (sev_v[h])
    );

    ecc_err_type_reg u_type (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .rd_clr_i  (stat_rd_i),
      .capture_i (capture),
      .base_i    (base_v[h]),
      .sev_i     (sev_v[h]),
      .type_q    (held_v[h])
    );
  end

  ecc_err_capture_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_clr_i  (stat_rd_i),
    .held_hi_i (held_v[1]),
    .held_lo_i (held_v[0]),
    .sev_hi_i  (sev_v[1]),
    .sev_lo_i  (sev_v[0]),
    .base_hi_o (base_v[1]),
    .base_lo_o (base_v[0]),
    .capture_o (capture)
  );

  logic [ADDR_W-1:0] addr_q;

  ecc_err_addr_reg #(
    .ADDR_W   (ADDR_W),
    .BEAT_LSB (BEAT_LSB),
    .HALF_LSB (HALF_LSB)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .capture_i (capture),
    .err_hi_i  (sev_v[1] != ERR_NONE),
    .err_lo_i  (sev_v[0] != ERR_NONE),
    .rd_addr_i (rd_addr_i),
    .addr_q    (addr_q)
  );

  always_comb begin
    status_o = '0;
    status_o[ADDR_W-1:0]               = addr_q;
    status_o[TYPE_LO_LSB +: TYPE_W]    = held_v[0];
    status_o[TYPE_HI_LSB +: TYPE_W]    = held_v[1];
  end

  // R1: reserved bits read zero
  always_comb begin
    assert_rsv_zero_R1: assert (status_o[TYPE_LO_LSB-1 -: RSV_W] == '0);
  end

  // R3: with nothing held and no read, an error is recorded
  assert_first_capture_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stat_rd_i && held_v[1] == ERR_NONE && held_v[0] == ERR_NONE &&
     (hi_sgl_err_i || hi_dbl_err_i || lo_sgl_err_i || lo_dbl_err_i))
    |=> (held_v[1] != ERR_NONE || held_v[0] != ERR_NONE));

  // R6: a held dual error freezes the status word
  assert_frozen_word_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!stat_rd_i && (held_v[1] == ERR_DUAL || held_v[0] == ERR_DUAL))
    |=> $stable(status_o));

  // R9: a dual error on a word, when captured, sets that word to dual
  assert_dual_wins_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (capture && hi_dbl_err_i) |=> (held_v[1] == ERR_DUAL));

endmodule

// File: tb/ecc_err_capture_tb.sv
module ecc_err_capture_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hs, hd, ls, ld, rd;
  logic [23:0] addr;
  logic [31:0] status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] last_exp;

  always #10 clk = ~clk;  // 50 MHz

  ecc_err_capture u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hi_sgl_err_i (hs),
    .hi_dbl_err_i (hd),
    .lo_sgl_err_i (ls),
    .lo_dbl_err_i (ld),
    .rd_addr_i    (addr),
    .stat_rd_i    (rd),
    .status_o     (status)
  );

  function automatic logic [31:0] mk(input int th, input int tl, input logic [23:0] a);
    return {th[1:0], tl[1:0], 4'b0000, a};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: status actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected result queued
  task automatic step(input logic h_s, input logic h_d, input logic l_s, input logic l_d,
                      input logic [23:0] a, input logic r,
                      input logic [31:0] exp, input string tag);
    @(negedge clk);
    hs = h_s; hd = h_d; ls = l_s; ld = l_d; addr = a; rd = r;
    if (r) begin
      #1 check(status, last_exp, "R12 pre-clear value during read");
    end
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    last_exp = exp;
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(status, e, t);
        if (status[31:30] == 2'd3 || status[29:28] == 2'd3) begin
          n_fail++;
          $display("FAIL R2: reserved type code, actual %h expected no code 3", status);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    hs = 0; hd = 0; ls = 0; ld = 0; rd = 0; addr = '0;
    rst_n = 1'b0;
    last_exp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(status, 32'h0, "R1 reset value");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    step(0,0,0,0, 24'h000000, 0, mk(0,0,24'h000000), "R1 idle stays zero");
    step(1,0,0,0, 24'h001230, 0, mk(1,0,24'h001238), "R3 R11 high single captured");
    step(0,0,1,0, 24'h000500, 0, mk(1,0,24'h001238), "R4 low single ignored");
    step(1,0,0,0, 24'h777770, 0, mk(1,0,24'h001238), "R4 high single ignored");
    step(0,0,0,1, 24'h00AB10, 0, mk(1,2,24'h00AB10), "R5 R2 dual overrides single");
    step(0,1,0,0, 24'h111110, 0, mk(1,2,24'h00AB10), "R6 dual frozen vs dual");
    step(1,0,1,0, 24'h222220, 0, mk(1,2,24'h00AB10), "R6 dual frozen vs single");
    step(0,0,0,0, 24'h000000, 1, mk(0,0,24'h00AB10), "R7 read clears types keeps addr");
    step(0,0,1,0, 24'h333338, 0, mk(0,1,24'h333330), "R11 R7 low single after rearm");
    step(0,1,0,0, 24'h444440, 1, mk(2,0,24'h444448), "R8 read with high dual");
    step(0,0,0,0, 24'h000000, 1, mk(0,0,24'h444448), "R7 read clears dual");
    step(1,0,1,0, 24'h55555C, 0, mk(1,1,24'h555550), "R10 both words single");
    step(1,0,0,1, 24'h666664, 0, mk(1,2,24'h666660), "R9 R10 mixed same cycle");
    step(0,0,0,0, 24'h000000, 1, mk(0,0,24'h666660), "R7 read clears mixed");
    step(1,1,0,0, 24'h777771, 0, mk(2,0,24'h777778), "R9 R2 single plus dual same word");
    step(0,0,1,0, 24'h999990, 0, mk(2,0,24'h777778), "R6 frozen after R9");
    step(0,0,1,0, 24'h888884, 1, mk(0,1,24'h888880), "R8 read with low single");
    step(0,0,0,0, 24'h000000, 1, mk(0,0,24'h888880), "R7 final read");
    step(0,0,0,0, 24'h000000, 0, mk(0,0,24'h888880), "R7 idle after read");

    @(negedge clk);
    hs = 0; hd = 0; ls = 0; ld = 0; rd = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule